// File: doc/BRIEF.md
# Multiplexed 16-bit External Bus Sequencer

This block runs external memory-mapped bus cycles for a small 8-bit processor core. A cycle can be a standard narrow access or a wide access that moves a full 16-bit word. Wide accesses suit disk-style and flash-card peripherals. The core raises a one-clock request with a direction, an address source and a low data byte. The block then owns the bus until the cycle ends. It drives an address-latch-enable pulse, active-low read and write strobes, and two byte-wide multiplexed ports. Each port has separate output, output-enable and input pins, so the pads sit outside the block. The low port carries address bits 7:0 and then data bits 7:0. The high port carries address bits 15:8 and then, in wide mode only, data bits 15:8.

A high-byte holding register sits beside the sequencer. The core loads it before a wide write, and its value becomes the upper data byte. A wide read loads the upper byte from the bus into the same register, and the lower byte returns on a separate output. When the address comes from an indirect register, the high port's address phase shows the core's port latch byte instead of an upper address. The same happens for a data-pointer access when page access is disabled. A stretch input widens the strobe for slow devices.

States, in order: `ST_IDLE` → `ST_ADDR` (address out, ALE high) → `ST_SETUP` (switch ports to the data phase) → `ST_STROBE` (RD or WR low) → `ST_HOLD` (strobe released, write data still driven) → `ST_IDLE`. Transitions: *accept* (request while idle), *addr_done*, *setup_done*, *strobe_done* (on the last strobe clock) and *cycle_done*.

Top module: `xbus_seq`

## Requirements
- R1: After reset, busy_o and ale_o are low, rd_n_o and wr_n_o are high, both output enables are low, and the holding register reads 0.
- R2: With stretch clear, the strobe is low for exactly 3 clocks and busy_o is high for exactly 6 clocks per cycle.
- R3: With stretch set, the strobe is low for exactly 15 clocks and busy_o is high for exactly 18 clocks.
- R4: ale_o is high for exactly one clock, the first clock after acceptance. During that clock p0_o carries address bits 7:0 with p0_oe_o high.
- R5: During the address phase, p2_o carries address bits 15:8. It carries p2_latch_i instead when ind_sel_i or page_dis_i is set. p2_oe_o is high.
- R6: On a narrow write, p0_o carries the low data byte during the strobe and p2_o keeps the upper address byte, with both ports driven.
- R7: On a wide write, p2_o carries the holding register value during the strobe, with p2_oe_o high.
- R8: On a write, p0_o stays driven with the write data for one clock after wr_n_o rises.
- R9: On a read, p0_oe_o is low for the whole strobe. p2_oe_o is also low in wide mode. In narrow mode p2 stays driven with the upper address byte.
- R10: On a narrow read, rdata_lo_o takes p0_i as sampled on the last strobe clock, rvalid_o pulses for one clock, and the holding register is unchanged.
- R11: On a wide read, rdata_lo_o takes p0_i and the holding register takes p2_i, both sampled on the last strobe clock.
- R12: A request that arrives while busy_o is high is ignored, and no second cycle follows.
- R13: hold_we_i loads hold_wdata_i into the holding register when the bus is not capturing read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, sampled while idle |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| ind_sel_i | input | 1 | Address comes from an indirect register |
| page_dis_i | input | 1 | Page access: high port shows latch in address phase |
| wide_en_i | input | 1 | 16-bit mode enable |
| stretch_i | input | 1 | Long strobe (15 clocks instead of 3) |
| addr_i | input | 16 | Access address (low byte only for indirect) |
| wdata_lo_i | input | 8 | Low write data byte |
| p2_latch_i | input | 8 | High port latch content |
| hold_we_i | input | 1 | Core write strobe for the holding register |
| hold_wdata_i | input | 8 | Core write data for the holding register |
| hold_q_o | output | 8 | Holding register value |
| rdata_lo_o | output | 8 | Low read data byte |
| rvalid_o | output | 1 | Read data valid pulse |
| busy_o | output | 1 | Cycle in progress |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| p0_o | output | 8 | Low port output value |
| p0_oe_o | output | 1 | Low port output enable |
| p0_i | input | 8 | Low port input value |
| p2_o | output | 8 | High port output value |
| p2_oe_o | output | 1 | High port output enable |
| p2_i | input | 8 | High port input value |

## Verification
A wrong strobe counter or a missed transition shows at once in the busy and strobe widths. A stuck state holds busy_o high past the sixth or eighteenth clock. A skipped state cuts the cycle short, and the bench counts both. A wrong output decode is visible within one clock. Examples are a port left driven while a read strobe is low, or a wrong byte during the address pulse. A capture on the wrong edge or into the wrong register appears on rdata_lo_o or hold_q_o as soon as the cycle returns to idle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int unsigned XB_BYTE = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } xbus_state_e;

    // request fields frozen at acceptance
    typedef struct packed {
        logic               write;
        logic               wide;
        logic               stretch;
        logic [XB_BYTE-1:0] a_lo;
        logic [XB_BYTE-1:0] a_hi;
        logic [XB_BYTE-1:0] d_lo;
        logic [XB_BYTE-1:0] d_hi;
    } xbus_req_t;

endpackage

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int unsigned SHORT_STB = 3,
    parameter int unsigned LONG_STB  = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  logic        stretch,
    output xbus_state_e state_q,
    output logic        stb_last
);
    localparam int unsigned CNT_W = $clog2(LONG_STB + 1);

    xbus_state_e       state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  stb_end;

    assign stb_end  = stretch ? CNT_W'(LONG_STB - 1) : CNT_W'(SHORT_STB - 1);
    assign stb_last = (state_q == ST_STROBE) && (cnt_q == stb_end);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)   state_d = ST_ADDR;
            ST_ADDR:                 state_d = ST_SETUP;
            ST_SETUP:                state_d = ST_STROBE;
            ST_STROBE: if (stb_last) state_d = ST_HOLD;
            ST_HOLD:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_STROBE) cnt_q <= cnt_q + 1'b1;
            else                      cnt_q <= '0;
        end
    end

    // R2
    hold_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (state_q == ST_IDLE));

    // R4
    setup_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP) |-> ($past(state_q) == ST_ADDR));

endmodule

// File: rtl/xbus_pad_mux.sv
module xbus_pad_mux
    import xbus_pkg::*;
(
    input  xbus_state_e        state_q,
    input  xbus_req_t          req_q,
    output logic               ale,
    output logic               rd_n,
    output logic               wr_n,
    output logic               rvalid,
    output logic [XB_BYTE-1:0] p0_val,
    output logic               p0_en,
    output logic [XB_BYTE-1:0] p2_val,
    output logic               p2_en
);
    logic data_phase;

    assign data_phase = (state_q == ST_SETUP) || (state_q == ST_STROBE)
                     || (state_q == ST_HOLD);

    always_comb begin
        ale    = (state_q == ST_ADDR);
        rd_n   = !((state_q == ST_STROBE) && !req_q.write);
        wr_n   = !((state_q == ST_STROBE) &&  req_q.write);
        rvalid = (state_q == ST_HOLD) && !req_q.write;
        p0_val = '0;
        p0_en  = 1'b0;
        p2_val = '0;
        p2_en  = 1'b0;
        if (state_q == ST_ADDR) begin
            p0_val = req_q.a_lo;
            p0_en  = 1'b1;
            p2_val = req_q.a_hi;
            p2_en  = 1'b1;
        end else if (data_phase) begin
            if (req_q.write) begin
                p0_val = req_q.d_lo;
                p0_en  = 1'b1;
                p2_val = req_q.wide ? req_q.d_hi : req_q.a_hi;
                p2_en  = 1'b1;
            end else begin
                p2_val = req_q.a_hi;
                p2_en  = !req_q.wide;
            end
        end
    end

endmodule

// File: rtl/xbus_hold_reg.sv
module xbus_hold_reg
    import xbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic [XB_BYTE-1:0] cap_d,
    input  logic               cpu_we,
    input  logic [XB_BYTE-1:0] cpu_d,
    output logic [XB_BYTE-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (cap_en) q <= cap_d;
        else if (cpu_we) q <= cpu_d;
    end

    // R13
    cpu_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !cap_en) |=> (q == $past(cpu_d)));

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int unsigned SHORT_STB = 3,
    parameter int unsigned LONG_STB  = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic                 write_i,
    input  logic                 ind_sel_i,
    input  logic                 page_dis_i,
    input  logic                 wide_en_i,
    input  logic                 stretch_i,
    input  logic [2*XB_BYTE-1:0] addr_i,
    input  logic [XB_BYTE-1:0]   wdata_lo_i,
    input  logic [XB_BYTE-1:0]   p2_latch_i,
    input  logic                 hold_we_i,
    input  logic [XB_BYTE-1:0]   hold_wdata_i,
    output logic [XB_BYTE-1:0]   hold_q_o,
    output logic [XB_BYTE-1:0]   rdata_lo_o,
    output logic                 rvalid_o,
    output logic                 busy_o,
    output logic                 ale_o,
    output logic                 rd_n_o,
    output logic                 wr_n_o,
    output logic [XB_BYTE-1:0]   p0_o,
    output logic                 p0_oe_o,
    input  logic [XB_BYTE-1:0]   p0_i,
    output logic [XB_BYTE-1:0]   p2_o,
    output logic                 p2_oe_o,
    input  logic [XB_BYTE-1:0]   p2_i
);
    xbus_state_e state_q;
    xbus_req_t   req_q;
    logic        accept;
    logic        stb_last;
    logic        rd_capture;

    assign accept     = req_i && (state_q == ST_IDLE);
    assign busy_o     = (state_q != ST_IDLE);
    assign rd_capture = stb_last && !req_q.write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q      <= '0;
            rdata_lo_o <= '0;
        end else begin
            if (accept) begin
                req_q.write   <= write_i;
                req_q.wide    <= wide_en_i;
                req_q.stretch <= stretch_i;
                req_q.a_lo    <= addr_i[XB_BYTE-1:0];
                req_q.a_hi    <= (ind_sel_i || page_dis_i) ? p2_latch_i
                                                           : addr_i[2*XB_BYTE-1:XB_BYTE];
                req_q.d_lo    <= wdata_lo_i;
                req_q.d_hi    <= hold_q_o;
            end
            if (rd_capture) rdata_lo_o <= p0_i;
        end
    end

    xbus_fsm #(
        .SHORT_STB (SHORT_STB),
        .LONG_STB  (LONG_STB)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .stretch  (req_q.stretch),
        .state_q  (state_q),
        .stb_last (stb_last)
    );

    xbus_pad_mux u_mux (
        .state_q (state_q),
        .req_q   (req_q),
        .ale     (ale_o),
        .rd_n    (rd_n_o),
        .wr_n    (wr_n_o),
        .rvalid  (rvalid_o),
        .p0_val  (p0_o),
        .p0_en   (p0_oe_o),
        .p2_val  (p2_o),
        .p2_en   (p2_oe_o)
    );

    xbus_hold_reg u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (rd_capture && req_q.wide),
        .cap_d  (p2_i),
        .cpu_we (hold_we_i),
        .cpu_d  (hold_wdata_i),
        .q      (hold_q_o)
    );

    // R9
    read_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !p0_oe_o);

    // R2
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o));

    // R4
    ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> (rd_n_o && wr_n_o && p0_oe_o));

    // R8
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n_o) |-> p0_oe_o);

    // R12
    ale_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale_o) |-> !$past(busy_o));

endmodule

// File: tb/xbus_seq_tb.sv
module xbus_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, write_i = 1'b0, ind_sel_i = 1'b0, page_dis_i = 1'b0;
    logic        wide_en_i = 1'b0, stretch_i = 1'b0, hold_we_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [7:0]  wdata_lo_i = '0, p2_latch_i = '0, hold_wdata_i = '0, p0_i = '0, p2_i = '0;
    logic [7:0]  hold_q_o, rdata_lo_o, p0_o, p2_o;
    logic        rvalid_o, busy_o, ale_o, rd_n_o, wr_n_o, p0_oe_o, p2_oe_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // per-access observations
    int n_ale, n_stb, n_busy, n_rv;
    int a_p0, a_p2, a_p0oe, a_p2oe;
    int s_p0, s_p2, s_p0oe, s_p2oe;
    int h_p0, h_p0oe;

    always #10 clk = ~clk;

    xbus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .write_i(write_i),
        .ind_sel_i(ind_sel_i), .page_dis_i(page_dis_i), .wide_en_i(wide_en_i),
        .stretch_i(stretch_i), .addr_i(addr_i), .wdata_lo_i(wdata_lo_i),
        .p2_latch_i(p2_latch_i), .hold_we_i(hold_we_i), .hold_wdata_i(hold_wdata_i),
        .hold_q_o(hold_q_o), .rdata_lo_o(rdata_lo_o), .rvalid_o(rvalid_o),
        .busy_o(busy_o), .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
        .p0_o(p0_o), .p0_oe_o(p0_oe_o), .p0_i(p0_i),
        .p2_o(p2_o), .p2_oe_o(p2_oe_o), .p2_i(p2_i)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one access; extra_k>0 pulses a second request on that clock of the cycle
    task automatic run_access(input bit w, input bit ind, input bit pgd, input bit wide,
                              input bit str, input logic [15:0] addr,
                              input logic [7:0] dlo, input int extra_k);
        bit prev_stb = 0;
        bit seen_s = 0;
        bit seen_h = 0;
        n_ale = 0; n_stb = 0; n_busy = 0; n_rv = 0;
        @(negedge clk);
        write_i = w; ind_sel_i = ind; page_dis_i = pgd; wide_en_i = wide;
        stretch_i = str; addr_i = addr; wdata_lo_i = dlo; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        for (int k = 1; k <= 26; k++) begin
            bit stb;
            stb = !rd_n_o || !wr_n_o;
            if (ale_o) begin
                n_ale++;
                a_p0 = p0_o; a_p2 = p2_o; a_p0oe = p0_oe_o; a_p2oe = p2_oe_o;
            end
            if (stb) begin
                n_stb++;
                if (!seen_s) begin
                    seen_s = 1;
                    s_p0 = p0_o; s_p2 = p2_o; s_p0oe = p0_oe_o; s_p2oe = p2_oe_o;
                end
            end
            if (prev_stb && !stb && !seen_h) begin
                seen_h = 1;
                h_p0 = p0_o; h_p0oe = p0_oe_o;
            end
            if (busy_o) n_busy++;
            if (rvalid_o) n_rv++;
            prev_stb = stb;
            req_i = (k == extra_k);
            @(negedge clk);
        end
        req_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 busy", busy_o, 0);
        chk("R1 ale", ale_o, 0);
        chk("R1 rd_n", rd_n_o, 1);
        chk("R1 wr_n", wr_n_o, 1);
        chk("R1 p0_oe", p0_oe_o, 0);
        chk("R1 p2_oe", p2_oe_o, 0);
        chk("R1 hold", hold_q_o, 0);
    endtask

    task automatic t_write8();
        run_access(1, 0, 0, 0, 0, 16'hA55A, 8'h3C, 0);
        chk("R4 ale count", n_ale, 1);
        chk("R4 addr lo", a_p0, 8'h5A);
        chk("R4 addr lo oe", a_p0oe, 1);
        chk("R5 addr hi", a_p2, 8'hA5);
        chk("R5 addr hi oe", a_p2oe, 1);
        chk("R2 strobe width", n_stb, 3);
        chk("R2 busy width", n_busy, 6);
        chk("R6 data lo", s_p0, 8'h3C);
        chk("R6 addr hi kept", s_p2, 8'hA5);
        chk("R6 p2 driven", s_p2oe, 1);
        chk("R8 hold driven", h_p0oe, 1);
        chk("R8 hold data", h_p0, 8'h3C);
    endtask

    task automatic t_write16();
        @(negedge clk);
        hold_we_i = 1'b1; hold_wdata_i = 8'hC7;
        @(negedge clk);
        hold_we_i = 1'b0;
        chk("R13 hold load", hold_q_o, 8'hC7);
        run_access(1, 0, 0, 1, 0, 16'h1234, 8'h99, 0);
        chk("R7 data hi", s_p2, 8'hC7);
        chk("R7 data hi oe", s_p2oe, 1);
        chk("R6 data lo wide", s_p0, 8'h99);
        chk("R2 busy wide", n_busy, 6);
    endtask

    task automatic t_read8();
        p0_i = 8'hE1; p2_i = 8'h77;
        run_access(0, 0, 0, 0, 0, 16'h4321, 8'h00, 0);
        chk("R9 p0 released", s_p0oe, 0);
        chk("R9 p2 driven narrow", s_p2oe, 1);
        chk("R9 p2 addr narrow", s_p2, 8'h43);
        chk("R10 rdata", rdata_lo_o, 8'hE1);
        chk("R10 hold unchanged", hold_q_o, 8'hC7);
        chk("R10 rvalid pulse", n_rv, 1);
    endtask

    task automatic t_read16_stretch();
        p0_i = 8'h5B; p2_i = 8'hD4;
        run_access(0, 0, 0, 1, 1, 16'h8001, 8'h00, 0);
        chk("R3 strobe width", n_stb, 15);
        chk("R3 busy width", n_busy, 18);
        chk("R9 p2 released wide", s_p2oe, 0);
        chk("R9 p0 released wide", s_p0oe, 0);
        chk("R11 rdata lo", rdata_lo_o, 8'h5B);
        chk("R11 hold captured", hold_q_o, 8'hD4);
    endtask

    task automatic t_addr_sources();
        p2_latch_i = 8'h6E;
        run_access(1, 1, 0, 0, 0, 16'h9F08, 8'h11, 0);
        chk("R5 indirect hi", a_p2, 8'h6E);
        chk("R4 indirect lo", a_p0, 8'h08);
        run_access(1, 0, 1, 0, 0, 16'h9F08, 8'h11, 0);
        chk("R5 page dis hi", a_p2, 8'h6E);
        run_access(1, 0, 0, 0, 1, 16'h9F08, 8'h11, 0);
        chk("R5 pointer hi", a_p2, 8'h9F);
        chk("R3 write stretch", n_stb, 15);
    endtask

    task automatic t_busy_req();
        run_access(1, 0, 0, 0, 0, 16'h0102, 8'h55, 3);
        chk("R12 single ale", n_ale, 1);
        chk("R12 busy width", n_busy, 6);
        chk("R12 idle after", busy_o, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write8();
        t_write16();
        t_read8();
        t_read16_stretch();
        t_addr_sources();
        t_busy_req();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule